// File: doc/BRIEF.md
# Exception Entry and Banked Register Swap Unit

This unit performs the architectural side of taking an exception on a 32-bit core. The core presents its current status word, program counter and the live contents of general registers 29 and 30 and of the saved-status register. It raises either an exception request with a type code or a plain mode-switch request. In the same clock edge the unit does three things. It picks the vector address and target mode. It stores the outgoing mode's copies of the three banked registers and brings in the incoming mode's copies. It produces the updated status word, saved status and link register. The core then writes these results back into its register file.

Six processor modes map onto five register banks. The two user-level modes share one bank. Both abort types enter the trap mode. A high-vector control input moves the vector table to the top of the address space. A request whose exception code is unknown, or whose current or target mode is not legal, raises an error pulse and leaves every bank and every result register as it was.

Top module: `exc_entry_core`

## Requirements
- R1: Modes map to banks as follows: user (0x10) and supervisor-user (0x1F) share bank 0, privileged (0x13) uses bank 1, trap (0x17) bank 2, extension (0x1B) bank 3, interrupt (0x12) bank 4. Switching between two modes that share a bank returns the live r29/r30/saved-status values unchanged.
- R2: On a mode change the live r29, r30 and saved status are stored into the old mode's bank, and the new mode's stored copies are presented on `out_r29`, `out_r30` and `out_ssr` (for a mode-switch request).
- R3: When the target mode equals the current mode (status bits [4:0]), no bank is written or read, and `out_r29` equals the live r29.
- R4: Exception codes: 0 privileged call → offset 0x08, mode privileged; 1 instruction abort → 0x0C, trap; 2 data abort → 0x10, trap; 3 interrupt → 0x18, interrupt.
- R5: With `hi_vec` high, 0xFFFF0000 is added to the vector offset.
- R6: On exception entry `out_ssr` is the whole current status word, and `out_status` is that word with bits [4:0] replaced by the new mode and bit 7 (interrupt disable) set. `out_mode` equals the new mode.
- R7: On exception entry `out_r30` is the current program counter and `out_pc` is the vector address.
- R8: An exception code of 4 to 7, a current mode or target mode outside the six legal values, gives `out_err` high and `out_valid` low. No bank is written and all result outputs keep their values.
- R9: Results appear one clock after the request edge, with `out_valid` high for exactly one cycle.
- R10: If `exc_req` and `sw_req` are both high, the exception is taken and the switch request is ignored.
- R11: After reset `out_valid`, `out_err` and all result outputs are zero, and every bank holds zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| exc_req | input | 1 | Exception entry request |
| exc_code | input | 3 | Exception type code |
| sw_req | input | 1 | Plain mode-switch request |
| sw_mode | input | 5 | Target mode for a switch request |
| hi_vec | input | 1 | Relocate vectors to the high base |
| cur_status | input | 32 | Current status word, mode in [4:0] |
| cur_pc | input | 32 | Current program counter (r31) |
| cur_r29 | input | 32 | Live register 29 |
| cur_r30 | input | 32 | Live register 30 |
| cur_ssr | input | 32 | Live saved-status register |
| out_valid | output | 1 | One-cycle pulse: results updated |
| out_err | output | 1 | One-cycle pulse: request rejected |
| out_pc | output | 32 | New program counter |
| out_mode | output | 5 | New mode |
| out_status | output | 32 | New status word |
| out_ssr | output | 32 | New saved-status register |
| out_r29 | output | 32 | New register 29 |
| out_r30 | output | 32 | New register 30 (link) |

## Verification
Every result is registered once, so the outputs of a request sampled at one rising edge are due right after that edge and stay until the next accepted request. The bench drives each request at a falling edge, holds it for one cycle and reads the results at the following falling edge. It reads once more a cycle later to confirm the valid pulse has dropped. The banked copies are observed only through later switch requests. Rejected requests are therefore followed by a switch that reads back the bank the bad request would have written.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;
  localparam int MODE_W  = 5;
  localparam int NBANK   = 5;
  localparam int BANK_W  = $clog2(NBANK);
  localparam int CODE_W  = 3;
  localparam int VOFF_W  = 8;
  localparam int IDIS_BIT = 7;

  typedef enum logic [MODE_W-1:0] {
    M_USER = 5'h10,
    M_INTR = 5'h12,
    M_PRIV = 5'h13,
    M_TRAP = 5'h17,
    M_EXTN = 5'h1B,
    M_SUSR = 5'h1F
  } mode_e;

  typedef enum logic [CODE_W-1:0] {
    EC_PCALL = 3'd0,
    EC_IABT  = 3'd1,
    EC_DABT  = 3'd2,
    EC_IRQ   = 3'd3
  } exc_code_e;

  typedef struct packed {
    logic              ok;
    logic [BANK_W-1:0] idx;
  } bank_sel_t;

  typedef struct packed {
    logic              ok;
    logic [MODE_W-1:0] mode;
    logic [VOFF_W-1:0] off;
  } vec_sel_t;

  function automatic bank_sel_t mode_bank(input logic [MODE_W-1:0] m);
    bank_sel_t r;
    r.ok = 1'b1;
    case (m)
      M_USER, M_SUSR: r.idx = BANK_W'(0);
      M_PRIV:         r.idx = BANK_W'(1);
      M_TRAP:         r.idx = BANK_W'(2);
      M_EXTN:         r.idx = BANK_W'(3);
      M_INTR:         r.idx = BANK_W'(4);
      default: begin
        r.ok  = 1'b0;
        r.idx = BANK_W'(0);
      end
    endcase
    return r;
  endfunction

  function automatic vec_sel_t code_vector(input logic [CODE_W-1:0] c);
    vec_sel_t r;
    r.ok = 1'b1;
    case (c)
      EC_PCALL: begin r.mode = M_PRIV; r.off = 8'h08; end
      EC_IABT:  begin r.mode = M_TRAP; r.off = 8'h0C; end
      EC_DABT:  begin r.mode = M_TRAP; r.off = 8'h10; end
      EC_IRQ:   begin r.mode = M_INTR; r.off = 8'h18; end
      default: begin
        r.ok   = 1'b0;
        r.mode = M_USER;
        r.off  = 8'h00;
      end
    endcase
    return r;
  endfunction
endpackage

// File: rtl/exc_vector_sel.sv
module exc_vector_sel
  import exc_entry_pkg::*;
#(
  parameter int              XLEN   = 32,
  parameter logic [XLEN-1:0] HI_BASE = 32'hFFFF0000
) (
  input  logic [CODE_W-1:0] code,
  input  logic              hi_vec,
  output logic              code_ok,
  output logic [MODE_W-1:0] tgt_mode,
  output logic [XLEN-1:0]   vec_addr
);
  vec_sel_t sel;

  always_comb begin
    sel      = code_vector(code);
    code_ok  = sel.ok;
    tgt_mode = sel.mode;
    vec_addr = XLEN'(sel.off) + (hi_vec ? HI_BASE : '0);
  end
endmodule

// File: rtl/exc_bank_file.sv
module exc_bank_file
  import exc_entry_pkg::*;
#(
  parameter int XLEN   = 32,
  parameter int BANKS  = NBANK,
  localparam int IDX_W = $clog2(BANKS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [XLEN-1:0]  wr_r29,
  input  logic [XLEN-1:0]  wr_r30,
  input  logic [XLEN-1:0]  wr_ssr,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [XLEN-1:0]  rd_r29,
  output logic [XLEN-1:0]  rd_r30,
  output logic [XLEN-1:0]  rd_ssr
);
  logic [XLEN-1:0] b29 [BANKS];
  logic [XLEN-1:0] b30 [BANKS];
  logic [XLEN-1:0] bss [BANKS];

  for (genvar g = 0; g < BANKS; g++) begin : g_bank
    logic hit;
    assign hit = we && (wr_idx == IDX_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        b29[g] <= '0;
        b30[g] <= '0;
        bss[g] <= '0;
      end else if (hit) begin
        b29[g] <= wr_r29;
        b30[g] <= wr_r30;
        bss[g] <= wr_ssr;
      end
    end
  end

  always_comb begin
    rd_r29 = '0;
    rd_r30 = '0;
    rd_ssr = '0;
    for (int i = 0; i < BANKS; i++) begin
      if (rd_idx == IDX_W'(i)) begin
        rd_r29 = b29[i];
        rd_r30 = b30[i];
        rd_ssr = bss[i];
      end
    end
  end
endmodule

// File: rtl/exc_status_upd.sv
module exc_status_upd
  import exc_entry_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0]   status_in,
  input  logic [MODE_W-1:0] new_mode,
  input  logic              on_entry,
  output logic [XLEN-1:0]   status_out
);
  function automatic logic [XLEN-1:0] set_mode(input logic [XLEN-1:0] s,
                                               input logic [MODE_W-1:0] m);
    logic [XLEN-1:0] r;
    r = s;
    r[MODE_W-1:0] = m;
    return r;
  endfunction

  function automatic logic [XLEN-1:0] mask_irq(input logic [XLEN-1:0] s);
    logic [XLEN-1:0] r;
    r = s;
    r[IDIS_BIT] = 1'b1;
    return r;
  endfunction

  always_comb begin
    status_out = set_mode(status_in, new_mode);
    if (on_entry) status_out = mask_irq(status_out);
  end
endmodule

// File: rtl/exc_entry_core.sv
module exc_entry_core
  import exc_entry_pkg::*;
#(
  parameter int              XLEN    = 32,
  parameter logic [XLEN-1:0] HI_BASE = 32'hFFFF0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              exc_req,
  input  logic [2:0]        exc_code,
  input  logic              sw_req,
  input  logic [4:0]        sw_mode,
  input  logic              hi_vec,
  input  logic [31:0]       cur_status,
  input  logic [31:0]       cur_pc,
  input  logic [31:0]       cur_r29,
  input  logic [31:0]       cur_r30,
  input  logic [31:0]       cur_ssr,
  output logic              out_valid,
  output logic              out_err,
  output logic [31:0]       out_pc,
  output logic [4:0]        out_mode,
  output logic [31:0]       out_status,
  output logic [31:0]       out_ssr,
  output logic [31:0]       out_r29,
  output logic [31:0]       out_r30
);
  logic              code_ok;
  logic [MODE_W-1:0] exc_mode;
  logic [XLEN-1:0]   vec_addr;
  logic [MODE_W-1:0] cur_mode;
  logic [MODE_W-1:0] tgt_mode;
  bank_sel_t         cur_bk;
  bank_sel_t         tgt_bk;
  logic              bad;
  logic              acc_exc;
  logic              acc_sw;
  logic              mode_chg;
  logic              bank_we;
  logic              fwd_live;
  logic [XLEN-1:0]   bk_r29, bk_r30, bk_ssr;
  logic [XLEN-1:0]   sel_r29, sel_r30, sel_ssr;
  logic [XLEN-1:0]   new_status;

  exc_vector_sel #(.XLEN(XLEN), .HI_BASE(HI_BASE)) u_vec (
    .code     (exc_code),
    .hi_vec   (hi_vec),
    .code_ok  (code_ok),
    .tgt_mode (exc_mode),
    .vec_addr (vec_addr)
  );

  always_comb begin
    cur_mode = cur_status[MODE_W-1:0];
    tgt_mode = exc_req ? exc_mode : sw_mode;
    cur_bk   = mode_bank(cur_mode);
    tgt_bk   = mode_bank(tgt_mode);
    bad      = (exc_req || sw_req) &&
               (!cur_bk.ok || !tgt_bk.ok || (exc_req && !code_ok));
    acc_exc  = exc_req && !bad;
    acc_sw   = sw_req && !exc_req && !bad;
    mode_chg = tgt_mode != cur_mode;
    bank_we  = (acc_exc || acc_sw) && mode_chg;
    fwd_live = !mode_chg || (tgt_bk.idx == cur_bk.idx);
    sel_r29  = fwd_live ? cur_r29 : bk_r29;
    sel_r30  = fwd_live ? cur_r30 : bk_r30;
    sel_ssr  = fwd_live ? cur_ssr : bk_ssr;
  end

  exc_bank_file #(.XLEN(XLEN), .BANKS(NBANK)) u_banks (
    .clk    (clk),
    .rst_n  (rst_n),
    .we     (bank_we),
    .wr_idx (cur_bk.idx),
    .wr_r29 (cur_r29),
    .wr_r30 (cur_r30),
    .wr_ssr (cur_ssr),
    .rd_idx (tgt_bk.idx),
    .rd_r29 (bk_r29),
    .rd_r30 (bk_r30),
    .rd_ssr (bk_ssr)
  );

  exc_status_upd #(.XLEN(XLEN)) u_stat (
    .status_in  (cur_status),
    .new_mode   (tgt_mode),
    .on_entry   (exc_req),
    .status_out (new_status)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_err    <= 1'b0;
      out_pc     <= '0;
      out_mode   <= '0;
      out_status <= '0;
      out_ssr    <= '0;
      out_r29    <= '0;
      out_r30    <= '0;
    end else begin
      out_valid <= acc_exc || acc_sw;
      out_err   <= bad;
      if (acc_exc) begin
        out_pc     <= vec_addr;
        out_mode   <= tgt_mode;
        out_status <= new_status;
        out_ssr    <= cur_status;
        out_r29    <= sel_r29;
        out_r30    <= cur_pc;
      end else if (acc_sw) begin
        out_pc     <= cur_pc;
        out_mode   <= tgt_mode;
        out_status <= new_status;
        out_ssr    <= sel_ssr;
        out_r29    <= sel_r29;
        out_r30    <= sel_r30;
      end
    end
  end
endmodule

// File: rtl/exc_entry_chk.sv
module exc_entry_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        exc_req,
  input logic        sw_req,
  input logic        hi_vec,
  input logic [31:0] cur_pc,
  input logic [31:0] cur_r29,
  input logic        acc_exc,
  input logic        acc_sw,
  input logic        bad,
  input logic        mode_chg,
  input logic        out_valid,
  input logic        out_err,
  input logic [31:0] out_pc,
  input logic [31:0] out_status,
  input logic [31:0] out_r29,
  input logic [31:0] out_r30
);
  AST_VALID_ERR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(out_valid && out_err)); // R8

  AST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_req || sw_req) |=> (out_valid || out_err)); // R9

  AST_IDIS_SET: assert property (@(posedge clk) disable iff (!rst_n)
    acc_exc |=> (out_valid && out_status[7])); // R6

  AST_LINK_PC: assert property (@(posedge clk) disable iff (!rst_n)
    acc_exc |=> (out_r30 == $past(cur_pc))); // R7

  AST_SAME_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    ((acc_exc || acc_sw) && !mode_chg) |=> (out_r29 == $past(cur_r29))); // R3

  AST_HIGH_BASE: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_exc && hi_vec) |=> (out_pc[31:16] == 16'hFFFF)); // R5

  AST_REJECT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    bad |=> (out_err && !out_valid && $stable(out_pc) && $stable(out_r29))); // R8

  AST_EXC_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_req && sw_req) |-> !acc_sw); // R10
endmodule

bind exc_entry_core exc_entry_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .exc_req    (exc_req),
  .sw_req     (sw_req),
  .hi_vec     (hi_vec),
  .cur_pc     (cur_pc),
  .cur_r29    (cur_r29),
  .acc_exc    (acc_exc),
  .acc_sw     (acc_sw),
  .bad        (bad),
  .mode_chg   (mode_chg),
  .out_valid  (out_valid),
  .out_err    (out_err),
  .out_pc     (out_pc),
  .out_status (out_status),
  .out_r29    (out_r29),
  .out_r30    (out_r30)
);

// File: tb/test_exc_entry_core.sv
module test_exc_entry_core;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        exc_req = 1'b0;
  logic [2:0]  exc_code = '0;
  logic        sw_req = 1'b0;
  logic [4:0]  sw_mode = '0;
  logic        hi_vec = 1'b0;
  logic [31:0] cur_status = '0, cur_pc = '0, cur_r29 = '0, cur_r30 = '0, cur_ssr = '0;
  logic        out_valid, out_err;
  logic [31:0] out_pc, out_status, out_ssr, out_r29, out_r30;
  logic [4:0]  out_mode;
  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  exc_entry_core i_exc_entry_core (
    .clk(clk), .rst_n(rst_n), .exc_req(exc_req), .exc_code(exc_code),
    .sw_req(sw_req), .sw_mode(sw_mode), .hi_vec(hi_vec),
    .cur_status(cur_status), .cur_pc(cur_pc), .cur_r29(cur_r29),
    .cur_r30(cur_r30), .cur_ssr(cur_ssr), .out_valid(out_valid),
    .out_err(out_err), .out_pc(out_pc), .out_mode(out_mode),
    .out_status(out_status), .out_ssr(out_ssr), .out_r29(out_r29),
    .out_r30(out_r30)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Drive one request at a falling edge; return one cycle later, results due.
  task automatic drive(input bit e, input bit s, input logic [2:0] code,
                       input logic [4:0] smode, input bit hv,
                       input logic [31:0] st, input logic [31:0] pc,
                       input logic [31:0] r29, input logic [31:0] r30,
                       input logic [31:0] ssr);
    @(negedge clk);
    exc_req = e; sw_req = s; exc_code = code; sw_mode = smode; hi_vec = hv;
    cur_status = st; cur_pc = pc; cur_r29 = r29; cur_r30 = r30; cur_ssr = ssr;
    @(negedge clk);
    exc_req = 1'b0; sw_req = 1'b0;
  endtask

  task automatic chk_drop(input string req);
    @(negedge clk);
    chk(req, "valid pulse ends", {31'b0, out_valid}, 32'd0);
  endtask

  task automatic t_reset;
    chk("R11", "valid", {31'b0, out_valid}, 0);
    chk("R11", "err",   {31'b0, out_err}, 0);
    chk("R11", "pc",    out_pc, 0);
    chk("R11", "r29",   out_r29, 0);
  endtask

  task automatic t_pcall_from_user;
    drive(1, 0, 3'd0, 5'h00, 0, 32'hA000_0010, 32'h0000_1234, 32'h11, 32'h22, 32'h33);
    chk("R9", "valid", {31'b0, out_valid}, 1);
    chk("R4", "pc", out_pc, 32'h08);
    chk("R6", "mode", {27'b0, out_mode}, 32'h13);
    chk("R6", "status", out_status, 32'hA000_0093);
    chk("R6", "ssr", out_ssr, 32'hA000_0010);
    chk("R7", "link", out_r30, 32'h1234);
    chk("R11", "bank1 r29 at reset", out_r29, 0);
    chk_drop("R9");
  endtask

  task automatic t_switch_back_user;
    drive(0, 1, 3'd0, 5'h10, 0, 32'hA000_0093, 32'h500, 32'h44, 32'h55, 32'h66);
    chk("R2", "r29", out_r29, 32'h11);
    chk("R2", "r30", out_r30, 32'h22);
    chk("R2", "ssr", out_ssr, 32'h33);
    chk("R2", "status", out_status, 32'hA000_0090);
  endtask

  task automatic t_dabt_high;
    drive(1, 0, 3'd2, 5'h00, 1, 32'h10, 32'h2000, 32'h77, 32'h88, 32'h99);
    chk("R5", "pc", out_pc, 32'hFFFF_0010);
    chk("R4", "mode", {27'b0, out_mode}, 32'h17);
    chk("R6", "status", out_status, 32'h97);
    chk("R7", "link", out_r30, 32'h2000);
  endtask

  task automatic t_shared_bank;
    drive(0, 1, 3'd0, 5'h1F, 0, 32'h17, 32'h0, 32'hAA, 32'hBB, 32'hCC);
    chk("R1", "susr r29 from bank0", out_r29, 32'h77);
    chk("R1", "susr ssr from bank0", out_ssr, 32'h99);
    drive(0, 1, 3'd0, 5'h10, 0, 32'h1F, 32'h0, 32'h1, 32'h2, 32'h3);
    chk("R1", "user<->susr r29", out_r29, 32'h1);
    chk("R1", "user<->susr r30", out_r30, 32'h2);
    drive(0, 1, 3'd0, 5'h13, 0, 32'h10, 32'h0, 32'h5, 32'h6, 32'h7);
    chk("R2", "priv r29", out_r29, 32'h44);
    chk("R2", "priv ssr", out_ssr, 32'h66);
  endtask

  task automatic t_same_mode;
    drive(1, 0, 3'd3, 5'h00, 0, 32'h12, 32'h3000, 32'hDEAD, 32'h1, 32'h2);
    chk("R3", "r29 kept", out_r29, 32'hDEAD);
    chk("R4", "irq pc", out_pc, 32'h18);
    chk("R6", "status", out_status, 32'h92);
  endtask

  task automatic t_iabt_high;
    drive(1, 0, 3'd1, 5'h00, 1, 32'h13, 32'h4000, 32'h8, 32'h9, 32'hA);
    chk("R5", "pc", out_pc, 32'hFFFF_000C);
    chk("R4", "mode", {27'b0, out_mode}, 32'h17);
    chk("R2", "trap bank r29", out_r29, 32'hAA);
  endtask

  task automatic t_reject;
    drive(1, 0, 3'd6, 5'h00, 0, 32'h13, 32'h0, 32'h99, 32'h99, 32'h99);
    chk("R8", "bad code err", {31'b0, out_err}, 1);
    chk("R8", "bad code valid", {31'b0, out_valid}, 0);
    chk("R8", "pc held", out_pc, 32'hFFFF_000C);
    drive(1, 0, 3'd0, 5'h00, 0, 32'h05, 32'h0, 32'h99, 32'h99, 32'h99);
    chk("R8", "bad cur mode err", {31'b0, out_err}, 1);
    drive(0, 1, 3'd0, 5'h00, 0, 32'h13, 32'h0, 32'h99, 32'h99, 32'h99);
    chk("R8", "bad tgt mode err", {31'b0, out_err}, 1);
    chk("R8", "r29 held", out_r29, 32'hAA);
    drive(0, 1, 3'd0, 5'h13, 0, 32'h1B, 32'h0, 32'h0, 32'h0, 32'h0);
    chk("R8", "bank1 r29 untouched", out_r29, 32'h8);
    chk("R8", "bank1 r30 untouched", out_r30, 32'h9);
    chk("R8", "bank1 ssr untouched", out_ssr, 32'hA);
  endtask

  task automatic t_both;
    drive(1, 1, 3'd0, 5'h1B, 0, 32'h10, 32'h6000, 32'h0, 32'h0, 32'h0);
    chk("R10", "valid", {31'b0, out_valid}, 1);
    chk("R10", "mode", {27'b0, out_mode}, 32'h13);
    chk("R10", "pc", out_pc, 32'h08);
    chk("R10", "r29", out_r29, 32'h8);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_pcall_from_user();
    t_switch_back_user();
    t_dabt_high();
    t_shared_bank();
    t_same_mode();
    t_iabt_high();
    t_reject();
    t_both();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule